// File: doc/BRIEF.md
# Byte-Order Conversion Unit

This unit carries out the endianness conversion instructions of a 64-bit register machine whose host byte order is little-endian. For each issued instruction it takes the 8-bit opcode, the 32-bit immediate and the current 64-bit value of the destination register. One cycle later it returns the converted value, which the caller writes back into that same register. No source register and no immediate data operand take part. The immediate only names the width of the conversion.

Two opcodes form the group, 0xd4 and 0xdc. Both carry the 32-bit arithmetic class (low three bits 3'b100) and operation code 0xd in bits 7:4. In this group, bit 3 of the opcode does not pick an operand source. It picks the byte order: 0 means little-endian and 1 means big-endian. The width is 16, 32 or 64 bits. Because the host is little-endian, the little-endian form only truncates to the width, and the big-endian form reverses the byte order of the low bytes. In both forms every bit above the width is cleared.

Any other immediate value is rejected and flagged as an illegal instruction. A rejected instruction produces no write. An opcode outside the two-member group is rejected the same way.

Top module: `byte_order_unit`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it, `out_valid`, `out_wen` and `out_illegal` are 0 and `out_value` is 0.
- R2: `out_valid` at a rising edge equals `in_valid` at the previous rising edge, so the latency is exactly one cycle.
- R3: With opcode 0xd4 (bit 3 = 0), an immediate of 16 gives `in_dst[15:0]` and an immediate of 32 gives `in_dst[31:0]`, each zero-extended to 64 bits. An immediate of 64 gives `in_dst` unchanged.
- R4: With opcode 0xdc (bit 3 = 1) and width N in {16, 32, 64}, byte k of the result (bits 8k+7:8k, k < N/8) equals byte N/8-1-k of `in_dst`. All bits from N upward are 0.
- R5: With either group opcode and an immediate other than 16, 32 or 64, the unit raises `out_illegal`, keeps `out_wen` at 0 and drives `out_value` to 0.
- R6: A valid opcode other than 0xd4 or 0xdc raises `out_illegal`, keeps `out_wen` at 0 and drives `out_value` to 0, whatever the immediate.
- R7: When `out_valid` is 1, exactly one of `out_wen` and `out_illegal` is 1. When `out_valid` is 0, both are 0 and `out_value` is 0.
- R8: Whenever `out_wen` is 1 after a 16-bit or 32-bit conversion, bits 63:16 or bits 63:32 of `out_value` respectively are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opcode | input | 8 | Instruction opcode |
| in_imm | input | 32 | Immediate holding the conversion width |
| in_dst | input | 64 | Current destination register value |
| out_valid | output | 1 | A result for the previous cycle's instruction is present |
| out_wen | output | 1 | Write `out_value` back to the destination register |
| out_illegal | output | 1 | Instruction rejected, nothing is written |
| out_value | output | 64 | Converted destination value |

## Verification
The assertions check on every cycle the following properties: the one-cycle valid pipeline, the mutual exclusion of write and reject, the zero upper bits after a narrow conversion, the pass-through of the 64-bit little-endian form, and the rejection of bad widths and foreign opcodes. The actual byte placement of each big-endian width and of the truncating forms can only be shown by the bench scenarios. In those scenarios, distinct byte patterns in the destination value expose any lane that is swapped or dropped. The scenarios also cover immediates next to the legal ones (0, 8, 15, 17, 128), the upper immediate bits, back-to-back issue and idle gaps.

// File: rtl/byte_order_unit.sv
module byte_order_unit #(
  parameter logic [7:0] OP_GROUP = 8'hd4,
  parameter logic [7:0] ORDER_BIT = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_opcode,
  input  logic [31:0] in_imm,
  input  logic [63:0] in_dst,
  output logic        out_valid,
  output logic        out_wen,
  output logic        out_illegal,
  output logic [63:0] out_value
);
  localparam int WORD_W = 64;
  localparam int NUM_W  = 3;

  logic [WORD_W-1:0] swapped [NUM_W];
  logic [WORD_W-1:0] conv;
  logic              group_hit, big, w16, w32, w64, legal;

  assign group_hit = (in_opcode & ~ORDER_BIT) == OP_GROUP;
  assign big       = |(in_opcode & ORDER_BIT);
  assign w16       = in_imm == 32'd16;
  assign w32       = in_imm == 32'd32;
  assign w64       = in_imm == 32'd64;
  assign legal     = in_valid && group_hit && (w16 || w32 || w64);

  for (genvar w = 0; w < NUM_W; w++) begin : g_width
    localparam int NB = 2 << w;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign swapped[w][8*b +: 8] = in_dst[8*(NB-1-b) +: 8];
    end
    if (NB * 8 < WORD_W) begin : g_fill
      assign swapped[w][WORD_W-1:NB*8] = '0;
    end
  end

  always_comb begin
    conv = in_dst;
    if (big) begin
      if (w16)      conv = swapped[0];
      else if (w32) conv = swapped[1];
      else          conv = swapped[2];
    end else begin
      if (w16)      conv = {48'd0, in_dst[15:0]};
      else if (w32) conv = {32'd0, in_dst[31:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_wen     <= 1'b0;
      out_illegal <= 1'b0;
      out_value   <= '0;
    end else begin
      out_valid   <= in_valid;
      out_wen     <= legal;
      out_illegal <= in_valid && !legal;
      out_value   <= legal ? conv : '0;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_wen, out_illegal}) == 1);
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_wen && !out_illegal && out_value == '0));
  a_r5_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm != 32'd16 && in_imm != 32'd32 && in_imm != 32'd64)
    |=> (out_illegal && !out_wen && out_value == '0));
  a_r6_foreign_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode != 8'hd4 && in_opcode != 8'hdc)
    |=> (out_illegal && !out_wen));
  a_r3_le64_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode == 8'hd4 && in_imm == 32'd64)
    |=> (out_wen && out_value == $past(in_dst)));
  a_r8_zero_above16: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm == 32'd16) |=> (out_value[63:16] == '0));
  a_r8_zero_above32: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_imm == 32'd32) |=> (out_value[63:32] == '0));
endmodule

// File: tb/test_byte_order_unit.sv
module test_byte_order_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_opcode = '0;
  logic [31:0] in_imm = '0;
  logic [63:0] in_dst = '0;
  logic        out_valid, out_wen, out_illegal;
  logic [63:0] out_value;
  int          checks = 0;
  int          errors = 0;

  byte_order_unit i_byte_order_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_imm(in_imm), .in_dst(in_dst), .out_valid(out_valid), .out_wen(out_wen),
    .out_illegal(out_illegal), .out_value(out_value)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] expect_val(input logic big, input int width, input logic [63:0] v);
    logic [63:0] r = '0;
    for (int k = 0; k < width/8; k++)
      r[8*k +: 8] = big ? v[8*(width/8-1-k) +: 8] : v[8*k +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] op, input logic [31:0] imm, input logic [63:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_imm = imm; in_dst = v;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk);
    #1 check("R1 during reset", {out_valid, out_wen, out_illegal, out_value}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first edge", {out_valid, out_wen, out_illegal, out_value}, '0);
  endtask

  task automatic t_little;
    logic [63:0] v = 64'h0123_4567_89ab_cdef;
    issue(8'hd4, 16, v);
    check("R3 le16", {out_valid, out_wen, out_illegal, out_value}, {3'b110, expect_val(0, 16, v)});
    issue(8'hd4, 32, v);
    check("R3 le32", {out_valid, out_wen, out_illegal, out_value}, {3'b110, 64'h0000_0000_89ab_cdef});
    issue(8'hd4, 64, v);
    check("R3 le64", {out_valid, out_wen, out_illegal, out_value}, {3'b110, v});
  endtask

  task automatic t_big;
    logic [63:0] v = 64'h1122_3344_5566_7788;
    issue(8'hdc, 16, v);
    check("R4 be16", {out_wen, out_value}, {1'b1, 64'h0000_0000_0000_8877});
    issue(8'hdc, 32, v);
    check("R4 be32", {out_wen, out_value}, {1'b1, 64'h0000_0000_8877_6655});
    issue(8'hdc, 64, v);
    check("R4 be64", {out_wen, out_value}, {1'b1, 64'h8877_6655_4433_2211});
    v = 64'hfedc_ba98_7654_3210;
    issue(8'hdc, 64, v);
    check("R4 be64 pattern2", {out_wen, out_value}, {1'b1, expect_val(1, 64, v)});
    issue(8'hdc, 16, 64'hffff_ffff_ffff_00ff);
    check("R8 be16 upper zero", {out_wen, out_value}, {1'b1, 64'h0000_0000_0000_ff00});
  endtask

  task automatic t_bad_imm;
    int bad [6] = '{0, 8, 15, 17, 128, 32'h0001_0010};
    foreach (bad[i]) begin
      issue(i % 2 ? 8'hdc : 8'hd4, bad[i], 64'hdead_beef_cafe_f00d);
      check("R5 bad width", {out_valid, out_wen, out_illegal, out_value}, {3'b101, 64'd0});
    end
  endtask

  task automatic t_bad_opcode;
    issue(8'hd5, 16, 64'h1234);
    check("R6 class bits", {out_wen, out_illegal, out_value}, {2'b01, 64'd0});
    issue(8'hc4, 32, 64'h1234);
    check("R6 op code", {out_wen, out_illegal, out_value}, {2'b01, 64'd0});
    issue(8'hd7, 64, 64'h1234);
    check("R6 wide class", {out_wen, out_illegal, out_value}, {2'b01, 64'd0});
  endtask

  task automatic t_stream;
    @(negedge clk);
    in_valid = 1'b1; in_opcode = 8'hdc; in_imm = 32; in_dst = 64'h0000_0000_aabb_ccdd;
    @(posedge clk); #1;
    in_opcode = 8'hd4; in_imm = 16; in_dst = 64'h9999_8888_7777_6666;
    check("R2 back to back first", {out_valid, out_wen, out_value}, {2'b11, 64'h0000_0000_ddcc_bbaa});
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R2 back to back second", {out_valid, out_wen, out_value}, {2'b11, 64'h0000_0000_0000_6666});
    @(posedge clk); #1;
    check("R7 idle after stream", {out_valid, out_wen, out_illegal, out_value}, '0);
    in_dst = 64'hffff; in_imm = 64; in_opcode = 8'hdc;
    @(posedge clk); #1;
    check("R2 no valid no result", {out_valid, out_wen, out_illegal, out_value}, '0);
  endtask

  initial begin
    t_reset();
    t_little();
    t_big();
    t_bad_imm();
    t_bad_opcode();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule